// File: doc/BRIEF.md
# Programmable System Clock Divider

This block slows the master clock seen by the processor and every peripheral, so that power drops when little work is pending. It does not generate a new clock. It produces a clock-enable pulse that downstream logic uses to qualify its master-clock registers. With the divider off, the pulse is high on every cycle. With the divider on, the pulse is high for one cycle in every N, where N = 129 − d and d is a 7-bit code held in the control register.

An 8-bit control register is written through a simple write strobe and can be read back at any time. The top bit is the enable. The lower seven bits are the divide code d. The code can be loaded only by the write that turns the enable on. Once the divider runs, the code is frozen. A write that clears the enable throws away whatever code it carries. A change of enable or divisor is applied only when the current divided period ends, so the pulse train never shows a runt or a stretched interval.

Top module: `sysclk_div`

## Requirements
- R1: After reset, the readback value is 0x00 and the clock enable is high on every cycle (divide by 1).
- R2: A write with bit 7 = 1 while the enable is 0 sets the enable and stores bits 6..0 as the code d. Readback then equals the written byte.
- R3: A write with bit 7 = 1 while the enable is already 1 leaves the stored code unchanged. The enable stays 1.
- R4: A write with bit 7 = 0 clears the enable and discards its bits 6..0. Readback becomes {0, previously stored code}.
- R5: While enabled with code d, the clock enable is a single-cycle pulse with a period of exactly 129 − d master cycles. The range spans 129 cycles at d = 0 and 2 cycles at d = 127.
- R6: A change of the enable takes effect only at the next pulse. After a disable write, the interval that is running completes at its full old length, and the enable is then high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write value: bit 7 is the enable, bits 6..0 are the code |
| rd_data | output | 8 | Readback: current enable and stored code |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
The divided period is measured for codes 0, 100, 120 and 127. These codes separate a correct 129 − d count from an off-by-one reload and from a wrong count width at both ends of the range. Register tests write an enable-set byte while already enabled and a byte with the enable clear. Each carries a code that differs from the stored one, so the tests show whether a rejected code leaks into the stored value. A disable write placed partway through a long period shows whether the switch waits for the period boundary or cuts the interval short.

// File: rtl/sysclk_div.sv
module sysclk_div #(
  parameter int CODE_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [CODE_W:0] wr_data,
  output logic [CODE_W:0] rd_data,
  output logic            clk_en
);
  localparam int CNT_W = CODE_W + 1;
  localparam logic [CNT_W-1:0] RELOAD_TOP = CNT_W'(2 ** CODE_W);

  logic              ena;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena  <= 1'b0;
      code <= '0;
    end else if (wr_en) begin
      if (wr_data[CODE_W]) begin
        if (!ena) begin
          ena  <= 1'b1;
          code <= wr_data[CODE_W-1:0];
        end
      end else begin
        ena <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (clk_en)
      cnt <= ena ? RELOAD_TOP - {1'b0, code} : '0;
    else
      cnt <= cnt - 1'b1;
  end

  assign clk_en  = (cnt == '0);
  assign rd_data = {ena, code};
endmodule

// File: rtl/sysclk_div_chk.sv
module sysclk_div_chk #(
  parameter int CODE_W = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [CODE_W:0] wr_data,
  input logic [CODE_W:0] rd_data,
  input logic            clk_en
);
  logic [CODE_W:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n)       gap <= '0;
    else if (clk_en)  gap <= '0;
    else              gap <= gap + 1'b1;
  end

  a_r2_load_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W] && !rd_data[CODE_W]) |=> (rd_data == $past(wr_data)));

  a_r3_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[CODE_W] && rd_data[CODE_W]) |=> (rd_data == $past(rd_data)));

  a_r4_discard_code: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[CODE_W]) |=> (rd_data == {1'b0, $past(rd_data[CODE_W-1:0])}));

  a_r1_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));

  a_r5_max_period: assert property (@(posedge clk) disable iff (!rst_n)
    (gap == (CODE_W+1)'(2 ** CODE_W)) |-> clk_en);

  a_r6_undivided_run: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_data[CODE_W] && clk_en) |=> clk_en);
endmodule

bind sysclk_div sysclk_div_chk #(.CODE_W(CODE_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .clk_en(clk_en)
);

// File: tb/test_sysclk_div.sv
module test_sysclk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clk_en;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sysclk_div i_sysclk_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_en(clk_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_gap(output int g);
    int guard = 0;
    while (!clk_en && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    g = 0;
    do begin
      @(negedge clk);
      g++;
    end while (!clk_en && g < 400);
  endtask

  task automatic t_reset;
    int highs = 0;
    check("R1 readback", rd_data, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (clk_en) highs++;
    end
    check("R1 enable every cycle", highs, 6);
  endtask

  task automatic t_period(input int d);
    int g;
    wr(8'h00);
    repeat (3) @(negedge clk);
    wr(8'h80 | 8'(d));
    check("R2 readback", rd_data, 32'h80 | d);
    get_gap(g);
    get_gap(g);
    check("R5 period", g, 129 - d);
    get_gap(g);
    check("R5 period repeat", g, 129 - d);
  endtask

  task automatic t_hold;
    int g;
    wr(8'h00);
    repeat (3) @(negedge clk);
    wr(8'hF8);
    wr(8'h85);
    check("R3 code held", rd_data, 32'hF8);
    get_gap(g);
    get_gap(g);
    check("R3 period unchanged", g, 9);
  endtask

  task automatic t_discard;
    int highs = 0;
    wr(8'h2A);
    check("R4 readback", rd_data, 32'h78);
    repeat (12) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (clk_en) highs++;
    end
    check("R4 undivided after disable", highs, 4);
  endtask

  task automatic t_boundary;
    int g;
    int n;
    int highs = 0;
    wr(8'h00);
    repeat (3) @(negedge clk);
    wr(8'h80 | 8'd100);
    get_gap(g);
    get_gap(g);
    wr(8'h00);
    n = 2;
    while (!clk_en && n < 400) begin
      @(negedge clk);
      n++;
    end
    check("R6 last interval full length", n, 29);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (clk_en) highs++;
    end
    check("R6 undivided after boundary", highs, 3);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period(0);
    t_period(127);
    t_period(100);
    t_hold();
    t_discard();
    t_boundary();
    finish_run();
  end
endmodule